// File: doc/BRIEF.md
# Integer Load Execution Unit

This unit carries out one decoded integer load at a time for a 64-bit big-endian register machine. The decoder hands it an access width, a sign flag, a byte-swap flag, a write-back flag, an addressing form, the base and target register indices, the two operand values and the immediate field. The unit computes the effective address and issues a single read on a request/acknowledge memory port. When the data comes back, it shapes the loaded bytes into a 64-bit register value and drives a register write port. It can also drive a second write port that returns the effective address to the base register.

A write-back form that names register 0 as base, or that names the same register as base and target, cannot be executed. The unit flags it instead and touches neither memory nor registers. The unit takes a new operation only while idle. It is meant to sit between an issue stage and a data memory port in an in-order pipeline.

Top module: `load_unit`

## Requirements
- R1: Without write-back, the address is base + offset, where base is `opRaVal` unless `opRa` is 0, in which case base is the constant 0. In the immediate form (`opForm`=0) the offset is the 16-bit `opDisp` sign-extended.
- R2: In the indexed form (`opForm`=2 or 3), `opRbVal` takes the place of the immediate offset.
- R3: In the scaled form (`opForm`=1), the offset is `opDisp[13:0]` followed by two zero bits, with the resulting 16-bit value sign-extended to 64 bits.
- R4: When `opSigned`=0 and `opReverse`=0, a load of 1, 2, 4 or 8 bytes (`opSize`=0,1,2,3) places the value in the low 8, 16, 32 or 64 bits and clears every bit above it.
- R5: When `opSigned`=1 and `opReverse`=0, the loaded value is sign-extended from its top bit to 64 bits.
- R6: When `opReverse`=1, the byte at the lowest address becomes the least significant byte of the result. The result is always zero-extended and `opSigned` has no effect.
- R7: When `opUpdate`=1 and the form is valid, the base is always `opRaVal`. The effective address is written to register `opRa` through `raWe`/`raIdx`/`raData`, in the same cycle as the target write.
- R8: When `opUpdate`=1 with `opRa`=0 or `opRa`=`opRt`, `illegal` is high for exactly the cycle after acceptance. No memory request is issued and no register write occurs.
- R9: `memReq` stays high, with `memAddr` and `memSize` unchanged, until the cycle in which `memAck` is seen. `memSize` carries the `opSize` code.
- R10: Read data is valid only in the acknowledge cycle, in the low bytes of `memRdata` in big-endian order. Bits above the access width are ignored. `rtWe` is high for the single cycle after the acknowledge, and `opReady` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation presented |
| opReady | output | 1 | Unit idle and accepting an operation |
| opSize | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| opSigned | input | 1 | Sign-extend the loaded value |
| opReverse | input | 1 | Swap byte order of the loaded value |
| opUpdate | input | 1 | Write the effective address back to the base register |
| opForm | input | 2 | 0 immediate, 1 scaled immediate, 2/3 indexed |
| opRa | input | 5 | Base register index |
| opRt | input | 5 | Target register index |
| opRaVal | input | 64 | Base register value |
| opRbVal | input | 64 | Index register value |
| opDisp | input | 16 | Immediate field |
| memReq | output | 1 | Read request |
| memAck | input | 1 | Read acknowledge, data valid |
| memAddr | output | 64 | Read address |
| memSize | output | 2 | Read width code |
| memRdata | input | 64 | Read data, big-endian in the low bytes |
| rtWe | output | 1 | Target register write enable |
| rtIdx | output | 5 | Target register index |
| rtData | output | 64 | Target register value |
| raWe | output | 1 | Base register write enable |
| raIdx | output | 5 | Base register index |
| raData | output | 64 | Effective address written back |
| illegal | output | 1 | Invalid write-back form detected |

## Verification
The hardest case to reach is the write-back form with a collision between base and target, or with a zero base index. Random register indices hit it only rarely, so the stimulus deliberately forces one in eight write-back operations into a collision and adds two directed cases. Garbage above the access width on the read bus only appears if the responder drives it, so every acknowledge fills all 64 bits with random data. A long acknowledge delay is forced once, so that address stability is checked over many wait cycles.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DWORD = 2'd3} sizeT;
  typedef enum logic [1:0] {FORM_D = 2'd0, FORM_DS = 2'd1, FORM_X = 2'd2, FORM_XALT = 2'd3} formT;
  typedef struct packed {
    logic captureOp;
    logic captureData;
    logic writeBack;
  } ctrlT;
endpackage

// File: rtl/ldu_ctrl.sv
module ldu_ctrl #(
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic            opUpdate,
  input  logic [REGW-1:0] opRa,
  input  logic [REGW-1:0] opRt,
  input  logic            memAck,
  output logic            opReady,
  output logic            memReq,
  output logic            illegal,
  output ldu_pkg::ctrlT   ctrl
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WB} stateT;
  stateT state, stateNext;
  logic badForm, accept;

  assign badForm = opUpdate && ((opRa == '0) || (opRa == opRt));
  assign accept  = (state == ST_IDLE) && opValid;

  always_comb begin
    ctrl.captureOp   = accept && !badForm;
    ctrl.captureData = (state == ST_REQ) && memAck;
    ctrl.writeBack   = (state == ST_WB);
    stateNext = state;
    case (state)
      ST_IDLE: if (accept && !badForm) stateNext = ST_REQ;
      ST_REQ:  if (memAck) stateNext = ST_WB;
      ST_WB:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      illegal <= 1'b0;
    end else begin
      state   <= stateNext;
      illegal <= accept && badForm;
    end
  end

  assign opReady = (state == ST_IDLE);
  assign memReq  = (state == ST_REQ);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  // R10
  ack_to_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> ctrl.writeBack && !memReq);
  // R8
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memReq && !ctrl.writeBack);
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> !memReq && !ctrl.writeBack);
endmodule

// File: rtl/ldu_datapath.sv
module ldu_datapath #(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int DISPW = 16,
  parameter int DSW   = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  ldu_pkg::ctrlT   ctrl,
  input  logic [1:0]      opSize,
  input  logic            opSigned,
  input  logic            opReverse,
  input  logic            opUpdate,
  input  logic [1:0]      opForm,
  input  logic [REGW-1:0] opRa,
  input  logic [REGW-1:0] opRt,
  input  logic [XLEN-1:0] opRaVal,
  input  logic [XLEN-1:0] opRbVal,
  input  logic [DISPW-1:0] opDisp,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [1:0]      memSize,
  output logic            rtWe,
  output logic [REGW-1:0] rtIdx,
  output logic [XLEN-1:0] rtData,
  output logic            raWe,
  output logic [REGW-1:0] raIdx,
  output logic [XLEN-1:0] raData
);
  import ldu_pkg::*;
  localparam int NSIZES = 4;

  logic [XLEN-1:0] base, offset, dOff, dsOff, ea;
  logic [DSW-1:0]  dsField;

  assign base    = (opUpdate || (opRa != '0)) ? opRaVal : '0;
  assign dOff    = XLEN'($signed(opDisp));
  assign dsField = opDisp[DSW-1:0];
  assign dsOff   = XLEN'($signed({dsField, 2'b00}));

  always_comb begin
    case (formT'(opForm))
      FORM_D:  offset = dOff;
      FORM_DS: offset = dsOff;
      default: offset = opRbVal;
    endcase
  end
  assign ea = base + offset;

  logic [XLEN-1:0] eaQ, resultQ;
  logic [1:0]      sizeQ;
  logic            signQ, revQ, updQ;
  logic [REGW-1:0] raQ, rtQ;
  logic [XLEN-1:0] cand [NSIZES];

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int NB = 1 << s;
    logic [8*NB-1:0] straight, reversed, picked;
    assign straight = memRdata[8*NB-1:0];
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign reversed[8*b +: 8] = straight[8*(NB-1-b) +: 8];
    end
    assign picked  = revQ ? reversed : straight;
    assign cand[s] = (signQ && !revQ) ? XLEN'($signed(picked)) : XLEN'(picked);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ <= '0; resultQ <= '0; sizeQ <= '0;
      signQ <= 1'b0; revQ <= 1'b0; updQ <= 1'b0;
      raQ <= '0; rtQ <= '0;
    end else begin
      if (ctrl.captureOp) begin
        eaQ   <= ea;
        sizeQ <= opSize;
        signQ <= opSigned;
        revQ  <= opReverse;
        updQ  <= opUpdate;
        raQ   <= opRa;
        rtQ   <= opRt;
      end
      if (ctrl.captureData) resultQ <= cand[sizeQ];
    end
  end

  assign memAddr = eaQ;
  assign memSize = sizeQ;
  assign rtWe    = ctrl.writeBack;
  assign rtIdx   = rtQ;
  assign rtData  = resultQ;
  assign raWe    = ctrl.writeBack && updQ;
  assign raIdx   = raQ;
  assign raData  = eaQ;

  // R4
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtWe && !signQ && (sizeQ == SZ_BYTE) |-> rtData[XLEN-1:8] == '0);
  // R6
  rev_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtWe && revQ && (sizeQ == SZ_HALF) |-> rtData[XLEN-1:16] == '0);
  // R7
  ra_write_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    raWe |-> rtWe && (raIdx != '0) && (raIdx != rtIdx));
endmodule

// File: rtl/load_unit.sv
module load_unit #(
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  parameter int DISPW = 16,
  parameter int DSW   = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  output logic             opReady,
  input  logic [1:0]       opSize,
  input  logic             opSigned,
  input  logic             opReverse,
  input  logic             opUpdate,
  input  logic [1:0]       opForm,
  input  logic [REGW-1:0]  opRa,
  input  logic [REGW-1:0]  opRt,
  input  logic [XLEN-1:0]  opRaVal,
  input  logic [XLEN-1:0]  opRbVal,
  input  logic [DISPW-1:0] opDisp,
  output logic             memReq,
  input  logic             memAck,
  output logic [XLEN-1:0]  memAddr,
  output logic [1:0]       memSize,
  input  logic [XLEN-1:0]  memRdata,
  output logic             rtWe,
  output logic [REGW-1:0]  rtIdx,
  output logic [XLEN-1:0]  rtData,
  output logic             raWe,
  output logic [REGW-1:0]  raIdx,
  output logic [XLEN-1:0]  raData,
  output logic             illegal
);
  ldu_pkg::ctrlT ctrl;

  ldu_ctrl #(.REGW(REGW)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opUpdate(opUpdate),
    .opRa(opRa), .opRt(opRt), .memAck(memAck), .opReady(opReady),
    .memReq(memReq), .illegal(illegal), .ctrl(ctrl)
  );

  ldu_datapath #(.XLEN(XLEN), .REGW(REGW), .DISPW(DISPW), .DSW(DSW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opSize(opSize), .opSigned(opSigned),
    .opReverse(opReverse), .opUpdate(opUpdate), .opForm(opForm), .opRa(opRa),
    .opRt(opRt), .opRaVal(opRaVal), .opRbVal(opRbVal), .opDisp(opDisp),
    .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize), .rtWe(rtWe),
    .rtIdx(rtIdx), .rtData(rtData), .raWe(raWe), .raIdx(raIdx), .raData(raData)
  );

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memSize));
  // R8
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !rtWe && !raWe);
endmodule

// File: tb/tb_load_unit.sv
`timescale 1ns/1ps
module tb_load_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [1:0]  opSize = '0;
  logic        opSigned = 1'b0, opReverse = 1'b0, opUpdate = 1'b0;
  logic [1:0]  opForm = '0;
  logic [4:0]  opRa = '0, opRt = '0;
  logic [63:0] opRaVal = '0, opRbVal = '0;
  logic [15:0] opDisp = '0;
  logic        memReq, memAck = 1'b0;
  logic [63:0] memAddr, memRdata = '0;
  logic [1:0]  memSize;
  logic        rtWe, raWe, illegal;
  logic [4:0]  rtIdx, raIdx;
  logic [63:0] rtData, raData;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  load_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady), .opSize(opSize),
    .opSigned(opSigned), .opReverse(opReverse), .opUpdate(opUpdate), .opForm(opForm),
    .opRa(opRa), .opRt(opRt), .opRaVal(opRaVal), .opRbVal(opRbVal), .opDisp(opDisp),
    .memReq(memReq), .memAck(memAck), .memAddr(memAddr), .memSize(memSize),
    .memRdata(memRdata), .rtWe(rtWe), .rtIdx(rtIdx), .rtData(rtData), .raWe(raWe),
    .raIdx(raIdx), .raData(raData), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] expEa(input logic [1:0] form, input bit upd, input logic [4:0] ra,
                                        input logic [63:0] raVal, input logic [63:0] rbVal,
                                        input logic [15:0] disp);
    logic [63:0] b, off;
    logic [15:0] ds;
    b = (upd || ra != 0) ? raVal : 64'd0;
    ds = {disp[13:0], 2'b00};
    if (form >= 2) off = rbVal;
    else if (form == 1) off = {{48{ds[15]}}, ds};
    else off = {{48{disp[15]}}, disp};
    return b + off;
  endfunction

  function automatic logic [63:0] expData(input logic [1:0] size, input bit sgn, input bit rev,
                                          input logic [63:0] rd);
    int nb;
    logic [63:0] v, bt;
    nb = 1 << size;
    v = 0;
    for (int i = 0; i < nb; i++) begin
      bt = (rd >> (8 * (nb - 1 - i))) & 64'hff;
      if (rev) v = v | (bt << (8 * i));
      else     v = v | (bt << (8 * (nb - 1 - i)));
    end
    if (sgn && !rev && nb < 8 && v[8*nb-1]) v = v | (~64'd0 << (8 * nb));
    return v;
  endfunction

  function automatic string eaTag(input logic [1:0] form, input bit upd);
    if (upd) return "R7";
    if (form >= 2) return "R2";
    if (form == 1) return "R3";
    return "R1";
  endfunction

  task automatic runOp(input logic [1:0] size, input bit sgn, input bit rev, input bit upd,
                       input logic [1:0] form, input logic [4:0] ra, input logic [4:0] rt,
                       input logic [63:0] raVal, input logic [63:0] rbVal, input logic [15:0] disp,
                       input logic [63:0] rd, input int waitCycles);
    logic [63:0] ea, exp;
    bit bad;
    string dTag;
    @(negedge clk);
    chk(opReady === 1'b1 && rtWe === 1'b0, "R10", {63'd0, opReady}, 64'd1);
    opSize = size; opSigned = sgn; opReverse = rev; opUpdate = upd; opForm = form;
    opRa = ra; opRt = rt; opRaVal = raVal; opRbVal = rbVal; opDisp = disp; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    bad = upd && (ra == 0 || ra == rt);
    if (bad) begin
      chk(illegal === 1'b1 && memReq === 1'b0, "R8", {62'd0, illegal, memReq}, 64'd2);
      @(negedge clk);
      chk(illegal === 1'b0 && memReq === 1'b0 && rtWe === 1'b0 && raWe === 1'b0, "R8",
          {60'd0, illegal, memReq, rtWe, raWe}, 64'd0);
      return;
    end
    ea = expEa(form, upd, ra, raVal, rbVal, disp);
    chk(illegal === 1'b0, "R8", {63'd0, illegal}, 64'd0);
    for (int w = 0; w < waitCycles; w++) begin
      chk(memReq === 1'b1 && memSize === size, "R9", {memSize, 61'd0, memReq}, {size, 61'd0, 1'b1});
      chk(memAddr === ea, "R9", memAddr, ea);
      @(negedge clk);
    end
    chk(memReq === 1'b1 && memSize === size, "R9", {memSize, 61'd0, memReq}, {size, 61'd0, 1'b1});
    chk(memAddr === ea, eaTag(form, upd), memAddr, ea);
    memAck = 1'b1; memRdata = rd;
    @(negedge clk);
    memAck = 1'b0; memRdata = {$urandom, $urandom};
    exp = expData(size, sgn, rev, rd);
    dTag = rev ? "R6" : (sgn ? "R5" : "R4");
    chk(rtWe === 1'b1 && rtIdx === rt && memReq === 1'b0, "R10", {58'd0, rtIdx, rtWe}, {58'd0, rt, 1'b1});
    chk(rtData === exp, dTag, rtData, exp);
    chk(raWe === upd, "R7", {63'd0, raWe}, {63'd0, upd});
    if (upd) chk(raIdx === ra && raData === ea, "R7", raData, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(memReq === 1'b0 && rtWe === 1'b0 && raWe === 1'b0 && illegal === 1'b0 && opReady === 1'b1,
        "R10", {59'd0, memReq, rtWe, raWe, illegal, opReady}, 64'd1);
    rstN = 1'b1;
    // R1: zero base index ignores the register value
    runOp(2'd2, 0, 0, 0, 2'd0, 5'd0, 5'd3, 64'hdead_beef_0000_0000, 64'd0, 16'hfff0, 64'h1122_3344_8899_aabb, 0);
    // R1: negative displacement with a real base
    runOp(2'd0, 0, 0, 0, 2'd0, 5'd4, 5'd5, 64'h1000, 64'd0, 16'h8000, 64'hffff_ffff_ffff_ff80, 1);
    // R3: negative scaled offset
    runOp(2'd3, 0, 0, 0, 2'd1, 5'd6, 5'd7, 64'h2000, 64'd0, 16'h3fff, 64'h0102_0304_0506_0708, 2);
    // R2: indexed
    runOp(2'd1, 0, 0, 0, 2'd2, 5'd8, 5'd9, 64'h100, 64'hffff_ffff_ffff_fffe, 16'h0, 64'haaaa_bbbb_cccc_8001, 0);
    // R5: negative halfword and word
    runOp(2'd1, 1, 0, 0, 2'd0, 5'd1, 5'd2, 64'h40, 64'd0, 16'h2, 64'h5555_5555_5555_9234, 0);
    runOp(2'd2, 1, 0, 0, 2'd0, 5'd1, 5'd2, 64'h40, 64'd0, 16'h4, 64'h5555_5555_8765_4321, 0);
    // R6: reversed word with sign flag set, reversed doubleword
    runOp(2'd2, 1, 1, 0, 2'd3, 5'd1, 5'd2, 64'h40, 64'h8, 16'h0, 64'h0000_0000_1122_33f4, 0);
    runOp(2'd3, 0, 1, 0, 2'd2, 5'd1, 5'd2, 64'h40, 64'h8, 16'h0, 64'h0102_0304_0506_0788, 1);
    // R7: valid write-back
    runOp(2'd2, 0, 0, 1, 2'd0, 5'd10, 5'd11, 64'h8000, 64'd0, 16'h10, 64'h0123_4567_89ab_cdef, 0);
    // R8: write-back with zero base, then with base equal to target
    runOp(2'd1, 0, 0, 1, 2'd0, 5'd0, 5'd11, 64'h8000, 64'd0, 16'h10, 64'h0, 0);
    runOp(2'd1, 0, 0, 1, 2'd2, 5'd12, 5'd12, 64'h8000, 64'h4, 16'h0, 64'h0, 0);
    // R9: long wait for acknowledge
    runOp(2'd3, 1, 0, 1, 2'd1, 5'd13, 5'd14, 64'h1_0000, 64'd0, 16'h0005, 64'hfedc_ba98_7654_3210, 9);
    for (int n = 0; n < 400; n++) begin
      logic [4:0] ra, rt;
      bit upd;
      upd = ($urandom % 3) == 0;
      ra = 5'($urandom);
      rt = 5'($urandom);
      if (upd && ($urandom % 8) != 0) begin
        if (ra == 0) ra = 5'd1;
        if (rt == ra) rt = ra + 5'd1;
      end else if (upd) begin
        if ($urandom % 2) ra = 5'd0; else rt = ra;
      end
      runOp(2'($urandom), 1'($urandom), 1'($urandom), upd, 2'($urandom), ra, rt,
            {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom), {$urandom, $urandom},
            int'($urandom % 4));
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule